// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers up to fifteen level-sensitive interrupt requests and presents them to a processor on one interrupt line. Inside, two eight-input priority units are chained. The secondary unit serves requests 8 to 15. Its "has a deliverable request" output stands in for input 2 of the primary unit, so request line 2 of the port cannot raise an interrupt by itself. Within each unit, a lower input number has the higher priority. The overall order from highest to lowest is therefore 0, 1, 8 through 15, then 3 through 7.

Software masks inputs one by one and programs two 5-bit vector bases, one per unit. When the processor pulses the acknowledge input, the block latches an 8-bit vector. The vector is the base of the granting unit followed by that unit's 3-bit input index. At the same time the block marks the winning request as in service. The line is raised again only for a request that outranks everything in service, so a more urgent source can preempt one that is being handled. A non-specific end-of-service pulse retires the most urgent in-service entry.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, `int_out` and `vec_valid` are 0. Every mask bit is 1, so no request is delivered. Both vector bases are 0.
- R2: Mask bit k (1 = masked) blocks request k. Mask bit 2 blocks all of requests 8 to 15 together. `irq_in[2]` never raises `int_out`. A mask write changes `int_out` from the clock edge that stores it.
- R3: Requests are levels sampled on every clock edge. `int_out` follows a request's rise or fall after the edge that samples it. A request must still be sampled when the acknowledge arrives in order to be granted.
- R4: When several unmasked requests compete, the grant goes to the first in the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R5: An acknowledge sampled at an edge with `int_out` high puts `vec_out` = {base, idx} after that edge. For requests 0 to 7, base is the primary base (`base_sel` = 0) and idx is the request number. For requests 8 to 15, base is the secondary base (`base_sel` = 1) and idx is the request number minus 8.
- R6: A granted request is in service. While it is in service, neither it nor any lower-priority request raises `int_out`.
- R7: `int_out` rises for a pending request that strictly outranks every in-service request, including a secondary request that outranks a secondary request already in service.
- R8: An acknowledge while `int_out` is low returns the primary base with index 7 and changes no in-service state.
- R9: An end-of-service pulse clears the highest-priority in-service request. For a secondary request, the primary's cascade entry is cleared only when no secondary request stays in service. A pulse with nothing in service has no effect.
- R10: Each acknowledge edge gives exactly one cycle of `vec_valid`, including back-to-back acknowledges, and `vec_valid` never rises otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Request levels; bit 2 has no effect |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 16 | New mask, 1 = masked; bit 2 masks 8 to 15 |
| base_we | input | 1 | Write strobe for a vector base |
| base_sel | input | 1 | 0 = primary base, 1 = secondary base |
| base_wdata | input | 5 | Base value |
| int_out | output | 1 | Interrupt line to the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| eoi | input | 1 | Non-specific end-of-service pulse |
| vec_out | output | 8 | Vector latched by the last acknowledge |
| vec_valid | output | 1 | High for one cycle after each acknowledge |

## Verification
A request or mask change takes effect at the next rising edge, and `int_out` is combinational from the registered state, so `int_out` is due one edge after the stimulus. An acknowledge or end-of-service pulse updates the vector and in-service state at the edge that samples it, so both are due one edge later as well. The bench drives on a falling edge and checks `int_out` on the following falling edge. A driver task queues the expected vector when it raises `ack`, and a monitor pops the queue on the falling edge on which `vec_valid` is high. That keeps every comparison exactly one edge behind its cause, including the back-to-back acknowledge case.

// File: rtl/irqc_pkg.sv
// Package: shared sizing for the cascaded interrupt controller.
// Assumes two identical units and a 3-bit index inside each unit.
package irqc_pkg;
    localparam int UNIT_N    = 8;
    localparam int IDX_W     = $clog2(UNIT_N);
    localparam int BASE_W    = 5;
    localparam int VEC_W     = BASE_W + IDX_W;
    localparam int CASC_PIN  = 2;
    localparam int NO_CASC   = -1;
endpackage

// File: rtl/irqc_resolver.sv
// irqc_resolver: combinational priority logic for one unit.
// Finds the lowest-numbered pending input, then decides whether it outranks
// every in-service bit. At the cascade pin an in-service bit at the same
// index does not block, because the chained unit arbitrates among its own
// requests. Also reports the most urgent in-service bit for end-of-service.
module irqc_resolver #(
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter int CASC = -1
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  isr,
    output logic          hit,
    output logic [IW-1:0] win,
    output logic [IW-1:0] isr_top,
    output logic          isr_any,
    output logic          isr_multi
);
    logic found;
    logic blocked;

    // Pick the winning pending input and test it against in-service bits.
    always_comb begin
        win     = '0;
        found   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win   = IW'(i);
                found = 1'b1;
            end
        end
        blocked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (isr[i]) begin
                if (i < int'(win))
                    blocked = 1'b1;
                else if (i == int'(win) && i != CASC)
                    blocked = 1'b1;
            end
        end
        hit = found && !blocked;
    end

    // Locate the most urgent in-service entry.
    always_comb begin
        isr_top = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (isr[i])
                isr_top = IW'(i);
        end
        isr_any   = |isr;
        isr_multi = |(isr & (isr - N'(1)));
    end
endmodule

// File: rtl/irqc_unit.sv
// irqc_unit: one eight-input priority unit with request sampling, mask and
// in-service registers. The input at CASC (if any) is taken live from the
// chained unit instead of being sampled, so a secondary request reaches the
// primary in the same cycle. Set takes precedence over clear on one bit.
module irqc_unit #(
    parameter int N    = 8,
    parameter int IW   = 3,
    parameter int CASC = -1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  raw_in,
    input  logic          live_in,
    input  logic          mask_we,
    input  logic [N-1:0]  mask_wdata,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic          hit,
    output logic [IW-1:0] win,
    output logic [N-1:0]  isr_q,
    output logic [N-1:0]  mask_q,
    output logic [IW-1:0] isr_top,
    output logic          isr_any,
    output logic          isr_multi
);
    logic [N-1:0] req_eff;
    logic [N-1:0] pend;
    logic [N-1:0] isr_n;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_req
            if (g == CASC) begin : g_chain
                logic unused_raw;
                assign unused_raw = raw_in[g];
                assign req_eff[g] = live_in;
            end else begin : g_smp
                logic smp_q;
                // Sample this request level every clock.
                always_ff @(posedge clk) begin
                    if (!rst_n) smp_q <= 1'b0;
                    else        smp_q <= raw_in[g];
                end
                assign req_eff[g] = smp_q;
            end
        end
        if (CASC < 0) begin : g_nolive
            logic unused_live;
            assign unused_live = live_in;
        end
    endgenerate

    assign pend = req_eff & ~mask_q;

    // Hold the mask; every input starts masked.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Next in-service state from clear and set requests.
    always_comb begin
        isr_n = isr_q;
        if (clr_en) isr_n[clr_idx] = 1'b0;
        if (set_en) isr_n[set_idx] = 1'b1;
    end

    // Hold the in-service bits.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_n;
    end

    irqc_resolver #(.N(N), .IW(IW), .CASC(CASC)) u_res (
        .pend      (pend),
        .isr       (isr_q),
        .hit       (hit),
        .win       (win),
        .isr_top   (isr_top),
        .isr_any   (isr_any),
        .isr_multi (isr_multi)
    );
endmodule

// File: rtl/irqc_vector.sv
// irqc_vector: holds the two programmable bases and latches the vector on
// each acknowledge. vec_valid is a one-cycle echo of the acknowledge.
module irqc_vector #(
    parameter int IW = 3,
    parameter int BW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           base_we,
    input  logic           base_sel,
    input  logic [BW-1:0]  base_wdata,
    input  logic           fire,
    input  logic           sel_sec,
    input  logic [IW-1:0]  idx,
    output logic [BW+IW-1:0] vec_out,
    output logic           vec_valid
);
    logic [BW-1:0] base_p;
    logic [BW-1:0] base_s;

    // Store the base written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_p <= '0;
            base_s <= '0;
        end else if (base_we) begin
            if (base_sel) base_s <= base_wdata;
            else          base_p <= base_wdata;
        end
    end

    // Latch the vector and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= fire;
            if (fire)
                vec_out <= {(sel_sec ? base_s : base_p), idx};
        end
    end
endmodule

// File: rtl/irqc_cascade.sv
// irqc_cascade: top of the two-unit interrupt controller. The secondary
// unit's deliverable-request flag feeds the primary's cascade pin. The top
// routes acknowledge grants and end-of-service clears between the two units.
// Assumes ack and eoi are one-cycle pulses synchronous to clk.
module irqc_cascade #(
    parameter int UNIT_N   = irqc_pkg::UNIT_N,
    parameter int BASE_W   = irqc_pkg::BASE_W,
    parameter int CASC_PIN = irqc_pkg::CASC_PIN,
    localparam int IW      = $clog2(UNIT_N),
    localparam int TOT     = 2 * UNIT_N,
    localparam int VEC_W   = BASE_W + IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TOT-1:0]    irq_in,
    input  logic              mask_we,
    input  logic [TOT-1:0]    mask_wdata,
    input  logic              base_we,
    input  logic              base_sel,
    input  logic [BASE_W-1:0] base_wdata,
    output logic              int_out,
    input  logic              ack,
    input  logic              eoi,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_valid
);
    localparam logic [IW-1:0] CASC_IDX  = IW'(CASC_PIN);
    localparam logic [IW-1:0] SPUR_IDX  = IW'(UNIT_N - 1);

    logic          p_hit, s_hit;
    logic [IW-1:0] p_win, s_win;
    logic [UNIT_N-1:0] p_isr, s_isr, p_mask, s_mask;
    logic [IW-1:0] p_top, s_top;
    logic          p_any, s_any, p_multi, s_multi;
    logic          grant, via_sec;
    logic          p_clr_en, s_clr_en;
    logic [IW-1:0] vec_idx;
    logic [TOT-1:0] isr_all;
    logic [TOT-1:0] mask_all;

    assign grant   = ack && p_hit;
    assign via_sec = grant && (p_win == CASC_IDX);
    assign int_out = p_hit;
    assign isr_all  = {s_isr, p_isr};
    assign mask_all = {s_mask, p_mask};

    // Index returned with the vector: granting unit's input, or the spurious code.
    always_comb begin
        if (!grant)       vec_idx = SPUR_IDX;
        else if (via_sec) vec_idx = s_win;
        else              vec_idx = p_win;
    end

    // Route a non-specific end-of-service to the right unit(s).
    always_comb begin
        p_clr_en = 1'b0;
        s_clr_en = 1'b0;
        if (eoi && p_any) begin
            if (p_top == CASC_IDX) begin
                s_clr_en = s_any;
                p_clr_en = !s_multi;
            end else begin
                p_clr_en = 1'b1;
            end
        end
    end

    irqc_unit #(.N(UNIT_N), .IW(IW), .CASC(irqc_pkg::NO_CASC)) u_sec (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (irq_in[TOT-1:UNIT_N]),
        .live_in    (1'b0),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata[TOT-1:UNIT_N]),
        .set_en     (via_sec),
        .set_idx    (s_win),
        .clr_en     (s_clr_en),
        .clr_idx    (s_top),
        .hit        (s_hit),
        .win        (s_win),
        .isr_q      (s_isr),
        .mask_q     (s_mask),
        .isr_top    (s_top),
        .isr_any    (s_any),
        .isr_multi  (s_multi)
    );

    irqc_unit #(.N(UNIT_N), .IW(IW), .CASC(CASC_PIN)) u_pri (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_in     (irq_in[UNIT_N-1:0]),
        .live_in    (s_hit),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata[UNIT_N-1:0]),
        .set_en     (grant),
        .set_idx    (p_win),
        .clr_en     (p_clr_en),
        .clr_idx    (p_top),
        .hit        (p_hit),
        .win        (p_win),
        .isr_q      (p_isr),
        .mask_q     (p_mask),
        .isr_top    (p_top),
        .isr_any    (p_any),
        .isr_multi  (p_multi)
    );

    logic unused_pmulti;
    assign unused_pmulti = p_multi;

    irqc_vector #(.IW(IW), .BW(BASE_W)) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_sel   (base_sel),
        .base_wdata (base_wdata),
        .fire       (ack),
        .sel_sec    (via_sec),
        .idx        (vec_idx),
        .vec_out    (vec_out),
        .vec_valid  (vec_valid)
    );
endmodule

// File: rtl/irqc_cascade_chk.sv
// irqc_cascade_chk: temporal checks on the controller, bound to the top.
module irqc_cascade_chk #(
    parameter int TOT   = 16,
    parameter int IW    = 3,
    parameter int VEC_W = 8,
    parameter int CASC  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             eoi,
    input logic             int_out,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic [TOT-1:0]   isr_all
);
    a_r5_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);

    a_r8_spurious_index: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> (vec_out[IW-1:0] == {IW{1'b1}}));

    a_r8_spurious_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !eoi) |=> $stable(isr_all));

    a_r9_cascade_entry_tracks_secondary: assert property (@(posedge clk) disable iff (!rst_n)
        isr_all[CASC] == (|isr_all[TOT-1:TOT/2]));

    a_r9_eoi_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack) |=> ((isr_all & ~$past(isr_all)) == '0));

    a_r6_grant_adds_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !eoi) |=> ($countones(isr_all) > $countones($past(isr_all))));
endmodule

bind irqc_cascade irqc_cascade_chk #(
    .TOT(TOT), .IW(IW), .VEC_W(VEC_W), .CASC(CASC_PIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .eoi       (eoi),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .isr_all   (isr_all)
);

// File: tb/sim_irqc_cascade.sv
// Scoreboard bench: the ack driver queues expected vectors from a
// behavioural model; a monitor compares them when vec_valid appears.
module sim_irqc_cascade;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in = '0;
    logic        mask_we = 1'b0;
    logic [15:0] mask_wdata = '0;
    logic        base_we = 1'b0;
    logic        base_sel = 1'b0;
    logic [4:0]  base_wdata = '0;
    logic        int_out;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] lv = '0;
    logic [15:0] mm = '1;
    logic [15:0] misr = '0;
    logic [4:0]  bp = '0;
    logic [4:0]  bs = '0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    irqc_cascade u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .base_we(base_we), .base_sel(base_sel),
        .base_wdata(base_wdata), .int_out(int_out), .ack(ack), .eoi(eoi),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    function automatic int irq_of_rank(int k);
        if (k < 2)  return k;
        if (k < 10) return k + 6;
        return k - 7;
    endfunction

    function automatic int rank_of(int irq);
        if (irq < 2)  return irq;
        if (irq >= 8) return irq - 6;
        return irq + 7;
    endfunction

    function automatic bit deliverable(int irq);
        return irq != 2 && lv[irq] && !mm[irq] && !(irq >= 8 && mm[2]);
    endfunction

    function automatic int best_req();
        for (int k = 0; k < 15; k++)
            if (deliverable(irq_of_rank(k))) return irq_of_rank(k);
        return -1;
    endfunction

    function automatic int top_isr();
        for (int k = 0; k < 15; k++)
            if (misr[irq_of_rank(k)]) return irq_of_rank(k);
        return -1;
    endfunction

    function automatic bit exp_int();
        int b = best_req();
        int t = top_isr();
        return b >= 0 && (t < 0 || rank_of(b) < rank_of(t));
    endfunction

    task automatic check(bit ok, string tag, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic check_int(string tag);
        check(int_out == exp_int(), tag, int_out, exp_int());
    endtask

    task automatic set_lv(logic [15:0] v, string tag);
        @(negedge clk);
        irq_in = v;
        lv = v;
        @(negedge clk);
        check_int(tag);
    endtask

    task automatic set_mask(logic [15:0] v, string tag);
        @(negedge clk);
        mask_we = 1'b1;
        mask_wdata = v;
        mm = v;
        @(negedge clk);
        mask_we = 1'b0;
        check_int(tag);
    endtask

    task automatic set_base(bit sel, logic [4:0] v);
        @(negedge clk);
        base_we = 1'b1;
        base_sel = sel;
        base_wdata = v;
        if (sel) bs = v; else bp = v;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    // Model one acknowledge: queue the expected vector and update in-service.
    task automatic model_ack(string tag);
        int b;
        if (exp_int()) begin
            b = best_req();
            exp_q.push_back(b < 8 ? {bp, 3'(b)} : {bs, 3'(b - 8)});
            misr[b] = 1'b1;
        end else begin
            exp_q.push_back({bp, 3'b111});
        end
        tag_q.push_back(tag);
    endtask

    task automatic do_ack(string tag);
        @(negedge clk);
        ack = 1'b1;
        model_ack(tag);
        @(negedge clk);
        ack = 1'b0;
        check_int(tag);
    endtask

    task automatic do_ack2(string tag);
        @(negedge clk);
        ack = 1'b1;
        model_ack(tag);
        @(negedge clk);
        model_ack(tag);
        @(negedge clk);
        ack = 1'b0;
        check_int(tag);
    endtask

    task automatic do_eoi(string tag);
        int t;
        @(negedge clk);
        eoi = 1'b1;
        t = top_isr();
        if (t >= 0) misr[t] = 1'b0;
        @(negedge clk);
        eoi = 1'b0;
        check_int(tag);
    endtask

    // Monitor: compare each produced vector with the queued expectation (R5, R10).
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected vec_valid", vec_out, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(vec_out == e, t, vec_out, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(int_out == 1'b0, "R1 int_out after reset", int_out, 0);
        check(vec_valid == 1'b0, "R1 vec_valid after reset", vec_valid, 0);
        set_lv(16'hFFFF, "R1 all masked at reset");
        set_lv(16'h0000, "R1 idle");
        do_ack("R1 zero base spurious");
        set_base(1'b0, 5'h08);
        set_base(1'b1, 5'h0E);
        set_mask(16'h0000, "R2 unmask all");

        // R3 level request rises and falls
        set_lv(16'h0020, "R3 request rise");
        do_ack("R5 primary vector irq5");
        do_eoi("R9 clear irq5");
        set_lv(16'h0000, "R3 request fall");

        // R4 fixed order across the cascade
        set_lv(16'h020A, "R4 irq1 irq3 irq9 pending");
        do_ack("R4 irq1 first");
        do_eoi("R9 clear irq1");
        do_ack("R4 irq9 before irq3");
        do_eoi("R9 clear irq9");
        do_ack("R4 irq3 last");
        do_eoi("R9 clear irq3");
        set_lv(16'h1008, "R4 irq12 vs irq3");
        do_ack("R4 irq12 wins");
        do_eoi("R9 clear irq12");
        set_lv(16'h0088, "R4 irq3 vs irq7");
        do_ack("R4 irq3 wins");
        do_eoi("R9 clear irq3 again");
        set_lv(16'h0000, "R3 idle");

        // R2 masks
        set_mask(16'h0004, "R2 cascade masked");
        set_lv(16'h0210, "R2 irq9 hidden by bit 2");
        do_ack("R2 irq4 granted");
        do_eoi("R9 clear irq4");
        set_lv(16'h0200, "R2 irq9 cascade mask only");
        set_mask(16'h0200, "R2 own mask bit 9");
        set_mask(16'h0000, "R2 unmask irq9");
        set_lv(16'h0004, "R2 irq_in 2 ignored");

        // R6 and R7 nesting on the primary
        set_lv(16'h0020, "R6 irq5 pending");
        do_ack("R6 irq5 granted");
        set_lv(16'h0060, "R6 irq6 held off");
        set_lv(16'h0061, "R7 irq0 preempts");
        do_ack("R7 irq0 vector");
        do_eoi("R9 clears irq0 first");
        do_eoi("R9 clears irq5 next");
        set_lv(16'h0000, "R3 drop all");
        do_eoi("R9 nothing in service");

        // R7 and R9 inside the secondary
        set_lv(16'h0400, "R7 irq10 pending");
        do_ack("R5 secondary vector irq10");
        set_lv(16'h0500, "R7 irq8 preempts irq10");
        do_ack("R7 irq8 vector");
        set_lv(16'h0D10, "R6 irq11 irq4 held off");
        do_eoi("R9 irq8 cleared, cascade kept");
        set_lv(16'h0C10, "R6 still held by irq10");
        do_eoi("R9 irq10 and cascade cleared");
        do_ack("R4 irq11 before irq4");
        do_eoi("R9 clear irq11");
        do_ack("R4 irq4 after");
        do_eoi("R9 clear irq4 b");
        set_lv(16'h0000, "R3 drop all b");

        // R8 spurious acknowledge keeps in-service state
        set_lv(16'h0020, "R8 irq5 pending");
        do_ack("R8 irq5 granted");
        set_lv(16'h0000, "R8 line dropped");
        do_ack("R8 spurious vector");
        do_eoi("R8 clear irq5");
        set_lv(16'h0080, "R8 irq7 not in service");
        set_lv(16'h0000, "R8 idle");
        do_eoi("R8 no stale entry");

        // R10 back-to-back acknowledges
        set_lv(16'h0003, "R10 irq0 irq1 pending");
        do_ack2("R10 back-to-back vectors");
        do_eoi("R10 clear irq0");
        do_ack("R10 irq1 vector");
        do_eoi("R10 clear irq1");
        set_lv(16'h0000, "R10 idle");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R10 all vectors produced", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule